// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer (three-wire host side)

This block is the host end of a three-wire serial EEPROM link. The memory holds 16-bit words at 6-bit addresses. A client hands over one command at a time through a valid/ready handshake, giving an operation code, an address and write data. The sequencer then builds the serial frame. The frame is a start bit, a two-bit opcode, six address bits and, for the write commands, sixteen data bits. The block drives chip select, a divided serial clock and the data line toward the memory. For a read, it gathers the returned word. For any command that programs the array, it keeps checking the memory's status line until the memory reports ready, and only then signals completion.

Each command ends with a one-cycle completion pulse. An error flag rides on that pulse when the status check gave up. Three inputs are software-set and can be changed between commands: the serial clock rate, the chip-select idle gap and the status-check limit. A hold input freezes the serial clock at its current level without corrupting the transfer.

Top module: `ueep_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle; a request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle after.
- R2: Every frame starts with a 1, then a two-bit opcode, then six address bits, all most significant bit first. Request codes on `req_op` and their opcodes are: 0 read (10), 1 write (01), 2 erase (11), 3 erase-all, 4 write-all, 5 write-enable and 6 write-disable. Codes 3 to 6 all use opcode 00, and their sub-code goes in the top two address bits: erase-all 10, write-all 01, enable 11, disable 00. The lower four address bits are then 0.
- R3: Erase, erase-all, enable and disable frames last 9 rising serial-clock edges. Write and write-all frames last 25, with the 16 data bits sent most significant bit first after the address.
- R4: While chip select is high, `mem_di` changes only in cycles where `mem_sk` is low, so it is stable at every rising edge of `mem_sk`.
- R5: `mem_sk` is low whenever `mem_cs` is low; during a frame each half period of `mem_sk` lasts `cfg_half_div`+1 system clocks.
- R6: A read frame lasts 26 rising edges. The bit sampled at rise 10 is a dummy and is discarded. The bits sampled from `mem_do` at rises 11 to 26 form `rd_data`, most significant bit first, and `rd_data` is valid in the cycle that `done` is high.
- R7: Between any fall and the next rise of `mem_cs`, chip select stays low for at least `cfg_cs_gap` system clocks; a value of 0 selects a default of ceil(250 ns × clock frequency), which is 63 clocks at 250 MHz.
- R8: After a write, write-all, erase or erase-all frame, the sequencer waits out the low gap, raises `mem_cs` again and samples `mem_do` each clock; the first 1 drops `mem_cs` and ends the command. Read, enable and disable raise `mem_cs` only once.
- R9: If `mem_do` is still 0 after `cfg_poll_limit`+1 status samples, the sequencer drops `mem_cs`, raises `err` together with `done`, and returns to idle.
- R10: `done` is high for exactly one cycle per command, and `err` is never high without `done`.
- R11: While `sclk_hold` is high, `mem_sk` and `mem_di` keep their levels, and the transfer resumes without loss when it is released.
- R12: During reset `mem_cs`, `mem_sk`, `done` and `err` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Sequencer idle, request accepted this edge if valid |
| req_op | input | 3 | Command code (see R2) |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Word to program (write, write-all) |
| cfg_half_div | input | DIV_W | Serial clock half period minus one, in system clocks |
| cfg_cs_gap | input | GAP_W | Minimum chip-select low time in system clocks, 0 = default |
| cfg_poll_limit | input | POLL_W | Status samples before giving up, minus one |
| sclk_hold | input | 1 | Freeze the serial clock at its current level |
| mem_cs | output | 1 | Chip select toward the memory |
| mem_sk | output | 1 | Serial clock toward the memory |
| mem_di | output | 1 | Serial data toward the memory |
| mem_do | input | 1 | Serial data and ready/busy status from the memory |
| rd_data | output | 16 | Word returned by the last read |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Status check timed out (with done) |

## Verification
The bench uses the default parameters, 250 MHz with 8-bit divider and gap fields and a 16-bit poll limit, so the default chip-select gap works out to 63 clocks. A zero gap setting is used once to reach that default, and a gap of 5 is used elsewhere so that the idle time before the status check can be measured exactly. Small half-period settings (0, 1 and 2) keep a 26-bit read short and allow the bench to measure the serial clock period. A poll limit of 20 against a memory model that never becomes ready reaches the timeout within a few dozen cycles.

// File: rtl/ueep_pkg.sv
package ueep_pkg;

    parameter int EE_ADDR_W = 6;
    parameter int EE_DATA_W = 16;

    // start bit + opcode + address
    localparam int HDR_W  = 3 + EE_ADDR_W;
    // longest outgoing frame (header + data word)
    localparam int TX_W   = HDR_W + EE_DATA_W;
    // read: header + dummy + data word
    localparam int RD_LEN = HDR_W + 1 + EE_DATA_W;
    localparam int CNT_W  = $clog2(RD_LEN + 1);

    typedef enum logic [2:0] {
        OP_READ      = 3'd0,
        OP_WRITE     = 3'd1,
        OP_ERASE     = 3'd2,
        OP_ERASE_ALL = 3'd3,
        OP_WRITE_ALL = 3'd4,
        OP_WR_EN     = 3'd5,
        OP_WR_DIS    = 3'd6
    } ee_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_SHIFT,
        ST_PGAP,
        ST_POLL
    } seq_st_e;

    typedef struct packed {
        ee_op_e                 op;
        logic [EE_ADDR_W-1:0]   addr;
        logic [EE_DATA_W-1:0]   data;
    } ee_cmd_t;

    // Left-aligned outgoing frame; bits past the frame length are zero.
    function automatic logic [TX_W-1:0] build_frame(ee_cmd_t c);
        logic [1:0]           oc;
        logic [EE_ADDR_W-1:0] a;
        logic [EE_DATA_W-1:0] d;
        a = c.addr;
        d = '0;
        case (c.op)
            OP_READ:      oc = 2'b10;
            OP_WRITE:     begin oc = 2'b01; d = c.data; end
            OP_ERASE:     oc = 2'b11;
            OP_ERASE_ALL: begin oc = 2'b00; a = {2'b10, {(EE_ADDR_W-2){1'b0}}}; end
            OP_WRITE_ALL: begin oc = 2'b00; a = {2'b01, {(EE_ADDR_W-2){1'b0}}}; d = c.data; end
            OP_WR_EN:     begin oc = 2'b00; a = {2'b11, {(EE_ADDR_W-2){1'b0}}}; end
            default:      begin oc = 2'b00; a = '0; end
        endcase
        return {1'b1, oc, a, d};
    endfunction

    function automatic logic [CNT_W-1:0] frame_len(ee_op_e op);
        case (op)
            OP_READ:                 return CNT_W'(RD_LEN);
            OP_WRITE, OP_WRITE_ALL:  return CNT_W'(TX_W);
            default:                 return CNT_W'(HDR_W);
        endcase
    endfunction

    function automatic logic needs_poll(ee_op_e op);
        return (op == OP_WRITE) || (op == OP_WRITE_ALL) ||
               (op == OP_ERASE) || (op == OP_ERASE_ALL);
    endfunction

endpackage

// File: rtl/ueep_sclk_gen.sv
module ueep_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             hold,
    input  logic [DIV_W-1:0] half_div,
    output logic             sk,
    output logic             rise_tk,
    output logic             fall_tk
);

    logic [DIV_W-1:0] cnt;
    logic             sk_q;
    logic             wrap;
    logic             adv;

    assign wrap    = (cnt >= half_div);
    assign adv     = run & ~hold & wrap;
    assign rise_tk = adv & ~sk_q;
    assign fall_tk = adv &  sk_q;
    assign sk      = sk_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            sk_q <= 1'b0;
        end else if (!hold) begin
            if (wrap) begin
                cnt  <= '0;
                sk_q <= ~sk_q;
            end else begin
                cnt  <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ueep_gap_timer.sv
module ueep_gap_timer #(
    parameter int GAP_W   = 8,
    parameter int DEF_GAP = 63
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs,
    input  logic [GAP_W-1:0] cfg_gap,
    output logic             gap_ok
);

    logic [GAP_W-1:0] cnt;
    logic [GAP_W-1:0] eff;

    assign eff    = (cfg_gap == '0) ? GAP_W'(DEF_GAP) : cfg_gap;
    assign gap_ok = (cnt >= eff);

    // Counts clocks with chip select low; out of reset it reads as long idle.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '1;
        end else if (cs) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ueep_shifter.sv
module ueep_shifter #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [TXW-1:0]        frame,
    input  logic                  rise_tk,
    input  logic                  fall_tk,
    input  logic                  cap_en,
    input  logic                  sdo,
    output logic                  sdi,
    output logic [CW-1:0]         nrise,
    output logic [DATA_W-1:0]     rx
);

    localparam int HDR = 3 + ADDR_W;
    localparam int TXW = HDR + DATA_W;
    localparam int CW  = $clog2(HDR + 1 + DATA_W + 1);

    logic [TXW-1:0] tx;

    assign sdi = tx[TXW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx    <= '0;
            nrise <= '0;
            rx    <= '0;
        end else if (load) begin
            tx    <= frame;
            nrise <= '0;
        end else begin
            if (fall_tk) begin
                tx <= tx << 1;
            end
            if (rise_tk) begin
                nrise <= nrise + 1'b1;
                // rises HDR+2 and later carry the data word
                if (cap_en && (nrise >= CW'(HDR + 1))) begin
                    rx <= {rx[DATA_W-2:0], sdo};
                end
            end
        end
    end

endmodule

// File: rtl/ueep_seq.sv
module ueep_seq
    import ueep_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int GAP_W   = 8,
    parameter int POLL_W  = 16,
    parameter int SYS_MHZ = 250
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [2:0]           req_op,
    input  logic [EE_ADDR_W-1:0] req_addr,
    input  logic [EE_DATA_W-1:0] req_wdata,
    input  logic [DIV_W-1:0]     cfg_half_div,
    input  logic [GAP_W-1:0]     cfg_cs_gap,
    input  logic [POLL_W-1:0]    cfg_poll_limit,
    input  logic                 sclk_hold,
    output logic                 mem_cs,
    output logic                 mem_sk,
    output logic                 mem_di,
    input  logic                 mem_do,
    output logic [EE_DATA_W-1:0] rd_data,
    output logic                 done,
    output logic                 err
);

    // ceil(250 ns * f) in system clocks
    localparam int DEF_GAP = (250 * SYS_MHZ + 999) / 1000;

    seq_st_e              st;
    ee_cmd_t              cmd;
    logic                 cs_q;
    logic                 run_q;
    logic                 done_q;
    logic                 err_q;
    logic [EE_DATA_W-1:0] rd_q;
    logic [POLL_W-1:0]    poll_cnt;

    logic                 rise_tk;
    logic                 fall_tk;
    logic                 gap_ok;
    logic                 load;
    logic                 last_edge;
    logic [CNT_W-1:0]     nrise;
    logic [EE_DATA_W-1:0] rx;

    assign load      = (st == ST_GAP) && gap_ok;
    assign last_edge = fall_tk && (nrise == frame_len(cmd.op));

    ueep_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
        .clk      (clk),
        .rst      (rst),
        .run      (run_q),
        .hold     (sclk_hold),
        .half_div (cfg_half_div),
        .sk       (mem_sk),
        .rise_tk  (rise_tk),
        .fall_tk  (fall_tk)
    );

    ueep_gap_timer #(.GAP_W(GAP_W), .DEF_GAP(DEF_GAP)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .cs      (cs_q),
        .cfg_gap (cfg_cs_gap),
        .gap_ok  (gap_ok)
    );

    ueep_shifter #(.ADDR_W(EE_ADDR_W), .DATA_W(EE_DATA_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .frame   (build_frame(cmd)),
        .rise_tk (rise_tk),
        .fall_tk (fall_tk),
        .cap_en  (cmd.op == OP_READ),
        .sdo     (mem_do),
        .sdi     (mem_di),
        .nrise   (nrise),
        .rx      (rx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cmd      <= '0;
            cs_q     <= 1'b0;
            run_q    <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            rd_q     <= '0;
            poll_cnt <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        cmd.op   <= ee_op_e'(req_op);
                        cmd.addr <= req_addr;
                        cmd.data <= req_wdata;
                        st       <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_ok) begin
                        cs_q  <= 1'b1;
                        run_q <= 1'b1;
                        st    <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (last_edge) begin
                        cs_q  <= 1'b0;
                        run_q <= 1'b0;
                        if (needs_poll(cmd.op)) begin
                            st <= ST_PGAP;
                        end else begin
                            done_q <= 1'b1;
                            st     <= ST_IDLE;
                            if (cmd.op == OP_READ) begin
                                rd_q <= rx;
                            end
                        end
                    end
                end
                ST_PGAP: begin
                    if (gap_ok) begin
                        cs_q     <= 1'b1;
                        poll_cnt <= '0;
                        st       <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (mem_do) begin
                        cs_q   <= 1'b0;
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end else if (poll_cnt == cfg_poll_limit) begin
                        cs_q   <= 1'b0;
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                        st     <= ST_IDLE;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign mem_cs    = cs_q;
    assign rd_data   = rd_q;
    assign done      = done_q;
    assign err       = err_q;

endmodule

// File: rtl/ueep_seq_chk.sv
module ueep_seq_chk #(
    parameter int GAP_W   = 8,
    parameter int SYS_MHZ = 250
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             sclk_hold,
    input logic [GAP_W-1:0] cfg_cs_gap,
    input logic             mem_cs,
    input logic             mem_sk,
    input logic             mem_di,
    input logic             done,
    input logic             err
);

    localparam int DEF_GAP = (250 * SYS_MHZ + 999) / 1000;

    logic [15:0] low_cnt;
    logic        seen_hi;
    logic [15:0] need;

    assign need = (cfg_cs_gap == '0) ? 16'(DEF_GAP) : 16'(cfg_cs_gap);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            seen_hi <= 1'b0;
        end else if (mem_cs) begin
            low_cnt <= '0;
            seen_hi <= 1'b1;
        end else if (low_cnt != 16'hFFFF) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R4
    di_setup_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_cs && $past(mem_cs) && !$stable(mem_di)) |-> !mem_sk);

    // R5
    sk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_cs |-> !mem_sk);

    // R7
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_cs) && seen_hi) |-> (low_cnt >= need));

    // R9
    timeout_cs_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !mem_cs);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R11
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sclk_hold) && $past(mem_cs) && mem_cs) |-> ($stable(mem_sk) && $stable(mem_di)));

endmodule

bind ueep_seq ueep_seq_chk #(.GAP_W(GAP_W), .SYS_MHZ(SYS_MHZ)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .sclk_hold  (sclk_hold),
    .cfg_cs_gap (cfg_cs_gap),
    .mem_cs     (mem_cs),
    .mem_sk     (mem_sk),
    .mem_di     (mem_di),
    .done       (done),
    .err        (err)
);

// File: tb/ueep_seq_tb.sv
module ueep_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [5:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [7:0]  cfg_half_div = 8'd1;
    logic [7:0]  cfg_cs_gap = 8'd5;
    logic [15:0] cfg_poll_limit = 16'd200;
    logic        sclk_hold = 1'b0;
    logic        mem_cs, mem_sk, mem_di, mem_do;
    logic [15:0] rd_data;
    logic        done, err;

    always #2 clk = ~clk;

    ueep_seq u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_half_div(cfg_half_div), .cfg_cs_gap(cfg_cs_gap),
        .cfg_poll_limit(cfg_poll_limit), .sclk_hold(sclk_hold),
        .mem_cs(mem_cs), .mem_sk(mem_sk), .mem_di(mem_di), .mem_do(mem_do),
        .rd_data(rd_data), .done(done), .err(err)
    );

    int n_chk = 0;
    int n_fail = 0;

    // ---------------- memory model ----------------
    int          fr_bits = 0;
    logic [31:0] fr_sh = '0;
    int          last_bits = 0;
    logic [31:0] last_sh = '0;
    logic        poll_mode = 1'b0;
    logic        rd_mode = 1'b0;
    logic        rd_bit = 1'b0;
    logic [15:0] rd_word = 16'h0;
    int          busy_cfg = 5;
    int          poll_cnt = 0;
    time         t_last_rise = 0;
    time         sk_per = 0;
    time         t_cs_fall = 0;
    time         last_low_ns = 0;
    int          cs_rises = 0;
    bit          fell_once = 0;
    int          viol_di = 0;
    int          viol_sk = 0;
    logic        prev_di = 1'b0;
    logic        prev_cs = 1'b0;

    always @(posedge mem_sk or negedge mem_cs) begin
        if (!mem_cs) begin
            if (poll_mode) begin
                poll_mode = 1'b0;
            end else begin
                last_bits = fr_bits;
                last_sh   = fr_sh;
                poll_mode = (fr_bits == 25) ||
                            (fr_bits == 9 && (fr_sh[7:6] == 2'b11 ||
                             (fr_sh[7:6] == 2'b00 && fr_sh[5:4] == 2'b10)));
            end
            fr_bits   = 0;
            fr_sh     = '0;
            rd_mode   = 1'b0;
            rd_bit    = 1'b0;
            t_cs_fall = $time;
            fell_once = 1;
        end else begin
            fr_sh = {fr_sh[30:0], mem_di};
            fr_bits++;
            if (fr_bits >= 2) sk_per = $time - t_last_rise;
            t_last_rise = $time;
            if (fr_bits == 9) rd_mode = (fr_sh[7:6] == 2'b10);
            if (rd_mode) begin
                if (fr_bits == 9) rd_bit = 1'b0;
                else if (fr_bits >= 10 && fr_bits <= 25) rd_bit = rd_word[25 - fr_bits];
            end
        end
    end

    always @(posedge mem_cs) begin
        cs_rises++;
        if (fell_once) last_low_ns = $time - t_cs_fall;
    end

    always @(posedge clk) begin
        if (!mem_cs) poll_cnt <= 0;
        else         poll_cnt <= poll_cnt + 1;
    end

    assign mem_do = poll_mode ? (poll_cnt >= busy_cfg) : rd_bit;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_cs && prev_cs && mem_di != prev_di && mem_sk) viol_di++;
            if (!mem_cs && mem_sk) viol_sk++;
        end
        prev_di = mem_di;
        prev_cs = mem_cs;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [5:0] addr,
                           input logic [15:0] data,
                           output logic got_err, output logic [15:0] got_rd);
        int wd;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cs_rises  = 0;
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = addr;
        req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R1", "ready after accept", 32'(req_ready), 32'd0);
        wd = 0;
        while (!done && wd < 20000) begin
            @(negedge clk);
            wd++;
        end
        chk(done == 1'b1, "R10", "done seen before timeout", 32'(done), 32'd1);
        got_err = err;
        got_rd  = rd_data;
        @(negedge clk);
        chk(done == 1'b0, "R10", "done single cycle", 32'(done), 32'd0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        repeat (3) @(negedge clk);
        chk(mem_cs == 1'b0 && mem_sk == 1'b0, "R12", "cs/sk in reset", {mem_cs, mem_sk}, 32'd0);
        chk(done == 1'b0 && err == 1'b0, "R12", "done/err in reset", {done, err}, 32'd0);
        chk(req_ready == 1'b1, "R12", "ready in reset", 32'(req_ready), 32'd1);
    endtask

    task automatic t_read_word();
        logic e; logic [15:0] r;
        cfg_half_div = 8'd0;
        rd_word = 16'hA55C;
        run_cmd(3'd0, 6'h2A, 16'h0, e, r);
        chk(last_bits == 26, "R6", "read frame length", 32'(last_bits), 32'd26);
        chk(last_sh[25:17] == 9'b1_10_101010, "R2", "read header", 32'(last_sh[25:17]), 32'h1AA);
        chk(r == 16'hA55C, "R6", "read data", 32'(r), 32'hA55C);
        chk(cs_rises == 1, "R8", "read has no status check", 32'(cs_rises), 32'd1);
        chk(sk_per == 8, "R5", "sk period half_div 0", 32'(sk_per), 32'd8);
    endtask

    task automatic t_write_word();
        logic e; logic [15:0] r;
        cfg_half_div = 8'd2;
        cfg_cs_gap   = 8'd5;
        busy_cfg     = 7;
        run_cmd(3'd1, 6'h15, 16'hBEEF, e, r);
        chk(last_bits == 25, "R3", "write frame length", 32'(last_bits), 32'd25);
        chk(last_sh[24:0] == {1'b1, 2'b01, 6'h15, 16'hBEEF}, "R3", "write frame bits",
            32'(last_sh[24:0]), 32'({1'b1, 2'b01, 6'h15, 16'hBEEF}));
        chk(cs_rises == 2, "R8", "write polls once more", 32'(cs_rises), 32'd2);
        chk(e == 1'b0, "R8", "write ready no error", 32'(e), 32'd0);
        chk(sk_per == 24, "R5", "sk period half_div 2", 32'(sk_per), 32'd24);
        chk(last_low_ns >= 20 && last_low_ns <= 28, "R7", "gap before status check",
            32'(last_low_ns), 32'd24);
    endtask

    task automatic t_erase_one();
        logic e; logic [15:0] r;
        cfg_half_div = 8'd1;
        busy_cfg = 3;
        run_cmd(3'd2, 6'h3F, 16'hFFFF, e, r);
        chk(last_bits == 9, "R3", "erase frame length", 32'(last_bits), 32'd9);
        chk(last_sh[8:0] == 9'b1_11_111111, "R2", "erase header", 32'(last_sh[8:0]), 32'h1FF);
        chk(cs_rises == 2 && e == 1'b0, "R8", "erase polls", 32'(cs_rises), 32'd2);
    endtask

    task automatic t_erase_all();
        logic e; logic [15:0] r;
        run_cmd(3'd3, 6'h0F, 16'h0, e, r);
        chk(last_sh[8:0] == 9'b1_00_100000 && last_bits == 9, "R2", "erase-all header",
            32'(last_sh[8:0]), 32'h120);
        chk(cs_rises == 2, "R8", "erase-all polls", 32'(cs_rises), 32'd2);
    endtask

    task automatic t_write_all();
        logic e; logic [15:0] r;
        run_cmd(3'd4, 6'h3F, 16'h1234, e, r);
        chk(last_bits == 25, "R3", "write-all length", 32'(last_bits), 32'd25);
        chk(last_sh[24:0] == {1'b1, 2'b00, 6'b010000, 16'h1234}, "R2", "write-all frame",
            32'(last_sh[24:0]), 32'({1'b1, 2'b00, 6'b010000, 16'h1234}));
        chk(cs_rises == 2, "R8", "write-all polls", 32'(cs_rises), 32'd2);
    endtask

    task automatic t_enable_disable();
        logic e; logic [15:0] r;
        run_cmd(3'd5, 6'h00, 16'h0, e, r);
        chk(last_sh[8:0] == 9'b1_00_110000 && last_bits == 9, "R2", "enable header",
            32'(last_sh[8:0]), 32'h130);
        chk(cs_rises == 1, "R8", "enable has no status check", 32'(cs_rises), 32'd1);
        run_cmd(3'd6, 6'h3F, 16'h0, e, r);
        chk(last_sh[8:0] == 9'b1_00_000000 && last_bits == 9, "R2", "disable header",
            32'(last_sh[8:0]), 32'h100);
        chk(cs_rises == 1, "R8", "disable has no status check", 32'(cs_rises), 32'd1);
    endtask

    task automatic t_poll_timeout();
        logic e; logic [15:0] r;
        cfg_poll_limit = 16'd20;
        busy_cfg = 100000;
        run_cmd(3'd2, 6'h01, 16'h0, e, r);
        chk(e == 1'b1, "R9", "timeout raises err", 32'(e), 32'd1);
        chk(mem_cs == 1'b0, "R9", "cs low after timeout", 32'(mem_cs), 32'd0);
        cfg_poll_limit = 16'd200;
        busy_cfg = 4;
        run_cmd(3'd2, 6'h01, 16'h0, e, r);
        chk(e == 1'b0, "R9", "no err when ready in time", 32'(e), 32'd0);
    endtask

    task automatic t_sclk_hold();
        logic e; logic [15:0] r;
        logic sk0, di0;
        int bad;
        cfg_half_div = 8'd1;
        rd_word = 16'h3C69;
        bad = 0;
        fork
            run_cmd(3'd0, 6'h11, 16'h0, e, r);
            begin
                wait (fr_bits == 5);
                @(negedge clk);
                sclk_hold = 1'b1;
                @(negedge clk);
                sk0 = mem_sk;
                di0 = mem_di;
                repeat (20) begin
                    @(negedge clk);
                    if (mem_sk != sk0 || mem_di != di0) bad++;
                end
                sclk_hold = 1'b0;
            end
        join
        chk(bad == 0, "R11", "sk/di frozen during hold", 32'(bad), 32'd0);
        chk(r == 16'h3C69, "R11", "read intact after hold", 32'(r), 32'h3C69);
        chk(last_sh[25:17] == 9'b1_10_010001, "R11", "header intact after hold",
            32'(last_sh[25:17]), 32'h191);
    endtask

    task automatic t_default_gap();
        logic e; logic [15:0] r;
        cfg_cs_gap = 8'd0;
        busy_cfg = 2;
        run_cmd(3'd2, 6'h05, 16'h0, e, r);
        chk(last_low_ns >= 252 && last_low_ns <= 260, "R7", "default gap 63 clocks",
            32'(last_low_ns), 32'd256);
        cfg_cs_gap = 8'd5;
    endtask

    task automatic t_edge_rules();
        chk(viol_di == 0, "R4", "di changed while sk high", 32'(viol_di), 32'd0);
        chk(viol_sk == 0, "R5", "sk high with cs low", 32'(viol_sk), 32'd0);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset_state();
        @(negedge clk);
        rst = 1'b0;
        t_read_word();
        t_write_word();
        t_erase_one();
        t_erase_all();
        t_write_all();
        t_enable_disable();
        t_poll_timeout();
        t_sclk_hold();
        t_default_gap();
        t_edge_rules();
        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule